// File: doc/BRIEF.md
# Interrupt Daisy-Chain Vector Responder

This block holds one device's place in a prioritized interrupt daisy chain. Eight internal pending-source bits feed it. It passes or blocks the chain enable for devices further down the chain, and it raises an active-low interrupt request when it is the highest-priority requester. It answers the CPU's single-cycle acknowledge strobe with an 8-bit vector on a bus that it can tri-state. A per-source under-service register records the acknowledged source, which allows higher sources to nest above it, and a clear command releases that source again. A combinational read port returns the stored vector, either unchanged or with the status code inserted.

Three control bits shape the answer. One bit cuts off every lower-priority device. One bit keeps the bus undriven during acknowledge. One bit puts the code of the highest requesting source into the vector. Source index equals status code: pending bit 7 is the highest priority. The bits decode as follows: 7 = first-channel receive special (3'b111), 6 = first-channel receive available (3'b110), 5 = first-channel external/status (3'b101), 4 = first-channel transmit empty (3'b100), 3 = second-channel receive special (3'b011), 2 = second-channel receive available (3'b010), 1 = second-channel external/status (3'b001), 0 = second-channel transmit empty (3'b000).

Top module: `irqc_chain`

## Requirements
- R1: While the cut-off bit (cfg_wdata[2] as last written) is 1, `ieo` is 0 whatever `iei` is.
- R2: A synchronous active-high `rst` clears the cut-off, no-vector and status-insert bits, the stored vector and every under-service bit to 0.
- R3: `ieo` is 1 only when all of these hold: `iei` is 1, the cut-off bit is 0, no under-service bit is set, and `mie` is 0 or `pend` is zero.
- R4: While the no-vector bit (cfg_wdata[1]) is 1, `bus_oe` stays 0 during acknowledge, even when the device is the selected requester, and the status-insert bit then has no effect on the bus.
- R5: When the status-insert bit (cfg_wdata[0]) is 1 and the no-vector bit is 0, the acknowledge vector is the stored vector with bits 3:1 replaced by the index of the highest requesting source. When the status-insert bit is 0, the stored vector goes out unchanged.
- R6: `int_req_n` is 0 exactly when `iei` and `mie` are 1 and some pending bit lies strictly above the highest set under-service bit. Such a bit is a requesting source.
- R7: `bus_oe` is 1 only in a cycle with `inta` high in which `int_req_n` is 0 and the no-vector bit is 0. `bus_dout` is 8'h00 whenever `bus_oe` is 0.
- R8: An acknowledge that finds `int_req_n` at 0 sets the under-service bit of the highest requesting source from the next cycle on. A `clr_ius` pulse clears the highest set under-service bit. When both happen in the same cycle, the clear acts on the old value and the set is applied after it.
- R9: With `rr2_chb` at 1, `rr2_data` is the stored vector with bits 3:1 set to the index of the highest pending bit, or 3'b000 when none is pending, whatever the status-insert bit is. With `rr2_chb` at 0, `rr2_data` is the stored vector unchanged.
- R10: A write with `base_we` loads `base_wdata` as the stored vector. A write with `cfg_we` loads the three control bits, which are cut-off, no-vector and status-insert from bit 2 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iei | input | 1 | Chain enable from the higher-priority neighbour |
| ieo | output | 1 | Chain enable to the lower-priority neighbour |
| pend | input | 8 | Pending sources, bit 7 highest priority |
| mie | input | 1 | Master interrupt enable |
| cfg_we | input | 1 | Control-bit write strobe |
| cfg_wdata | input | 3 | {cut-off, no-vector, status-insert} |
| base_we | input | 1 | Stored-vector write strobe |
| base_wdata | input | 8 | New stored vector |
| inta | input | 1 | Single-cycle interrupt acknowledge |
| clr_ius | input | 1 | Clear the highest under-service bit |
| int_req_n | output | 1 | Active-low interrupt request (open-drain style) |
| bus_dout | output | 8 | Vector driven during acknowledge |
| bus_oe | output | 1 | Output enable of the vector bus |
| rr2_chb | input | 1 | Read-port channel select: 1 = status-modified |
| rr2_data | output | 8 | Read-port vector |

## Verification
The hardest state to reach from the ports is a nested one. A lower source is still pending but masked by its own under-service bit while the device blocks the chain for the devices below it. A higher source of the same device can still break through, and after a clear the masked source must request again. The bench chains three devices. It acknowledges one source, withdraws and re-raises pending bits, and issues clear commands in between. A long random phase mixes acknowledges, clears, control writes and chain-enable drops, and a behavioural model follows every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC     = 8;
    localparam int VEC_W    = 8;
    localparam int CODE_W   = $clog2(NSRC);
    localparam int CODE_LSB = 1;

    typedef struct packed {
        logic dlc;   // cut off lower chain
        logic nv;    // no vector on acknowledge
        logic vis;   // insert status code
    } irqc_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } irqc_pick_t;

    // Highest set bit of a source vector; code 0 when empty.
    function automatic irqc_pick_t pick_top(input logic [NSRC-1:0] v);
        irqc_pick_t p;
        p = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.code  = CODE_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [VEC_W-1:0] with_status(input logic [VEC_W-1:0] base,
                                                      input logic [CODE_W-1:0] code);
        logic [VEC_W-1:0] v;
        v = base;
        v[CODE_LSB +: CODE_W] = code;
        return v;
    endfunction

    // Sources strictly above the highest bit under service.
    function automatic logic [NSRC-1:0] above_mask(input logic [NSRC-1:0] ius);
        irqc_pick_t       top;
        logic [NSRC-1:0]  m;
        top = pick_top(ius);
        for (int i = 0; i < NSRC; i++) begin
            m[i] = !top.valid || (CODE_W'(i) > top.code);
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter logic [VEC_W-1:0] BASE_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  irqc_cfg_t        cfg_wdata,
    input  logic             base_we,
    input  logic [VEC_W-1:0] base_wdata,
    output irqc_cfg_t        cfg_q,
    output logic [VEC_W-1:0] base_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            base_q <= BASE_RST;
        end else begin
            if (cfg_we)  cfg_q  <= cfg_wdata;
            if (base_we) base_q <= base_wdata;
        end
    end

endmodule

// File: rtl/irqc_ius_tracker.sv
module irqc_ius_tracker
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  logic [CODE_W-1:0] ack_code,
    input  logic              clr_top,
    output logic [NSRC-1:0]   ius_q,
    output logic [NSRC-1:0]   allow_mask
);

    irqc_pick_t      ius_top;
    logic [NSRC-1:0] ius_next;

    assign ius_top    = pick_top(ius_q);
    assign allow_mask = above_mask(ius_q);

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_bit
            logic hit_clr;
            logic hit_set;
            assign hit_clr     = clr_top && ius_top.valid && (ius_top.code == CODE_W'(g));
            assign hit_set     = ack && (ack_code == CODE_W'(g));
            assign ius_next[g] = (ius_q[g] && !hit_clr) || hit_set;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ius_q <= '0;
        else     ius_q <= ius_next;
    end

endmodule

// File: rtl/irqc_vector_mux.sv
module irqc_vector_mux
    import irqc_pkg::*;
(
    input  logic [VEC_W-1:0] base,
    input  irqc_cfg_t        cfg,
    input  irqc_pick_t       req_pick,
    input  irqc_pick_t       pend_pick,
    input  logic             ack_go,
    input  logic             rd_chb,
    output logic [VEC_W-1:0] bus_dout,
    output logic             bus_oe,
    output logic [VEC_W-1:0] rd_data
);

    logic [VEC_W-1:0] ack_vec;

    always_comb begin
        ack_vec  = cfg.vis ? with_status(base, req_pick.code) : base;
        bus_oe   = ack_go && !cfg.nv;
        bus_dout = bus_oe ? ack_vec : '0;
        rd_data  = rd_chb ? with_status(base, pend_pick.code) : base;
    end

endmodule

// File: rtl/irqc_chain.sv
module irqc_chain
    import irqc_pkg::*;
#(
    parameter logic [VEC_W-1:0] BASE_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iei,
    output logic             ieo,
    input  logic [NSRC-1:0]  pend,
    input  logic             mie,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_wdata,
    input  logic             base_we,
    input  logic [VEC_W-1:0] base_wdata,
    input  logic             inta,
    input  logic             clr_ius,
    output logic             int_req_n,
    output logic [VEC_W-1:0] bus_dout,
    output logic             bus_oe,
    input  logic             rr2_chb,
    output logic [VEC_W-1:0] rr2_data
);

    irqc_cfg_t        cfg_q;
    logic [VEC_W-1:0] base_q;
    logic [NSRC-1:0]  ius_q;
    logic [NSRC-1:0]  allow_mask;
    logic [NSRC-1:0]  req_vec;
    irqc_pick_t       req_pick;
    irqc_pick_t       pend_pick;
    logic             selected;
    logic             ack_go;

    irqc_cfg_regs #(.BASE_RST(BASE_RST)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (irqc_cfg_t'(cfg_wdata)),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .cfg_q      (cfg_q),
        .base_q     (base_q)
    );

    assign req_vec   = pend & allow_mask;
    assign req_pick  = pick_top(req_vec);
    assign pend_pick = pick_top(pend);
    assign selected  = iei && mie && req_pick.valid;
    assign ack_go    = inta && selected;
    assign int_req_n = !selected;
    assign ieo       = iei && !cfg_q.dlc && !(|ius_q) && !(mie && (|pend));

    irqc_ius_tracker u_ius (
        .clk        (clk),
        .rst        (rst),
        .ack        (ack_go),
        .ack_code   (req_pick.code),
        .clr_top    (clr_ius),
        .ius_q      (ius_q),
        .allow_mask (allow_mask)
    );

    irqc_vector_mux u_vec (
        .base      (base_q),
        .cfg       (cfg_q),
        .req_pick  (req_pick),
        .pend_pick (pend_pick),
        .ack_go    (ack_go),
        .rd_chb    (rr2_chb),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .rd_data   (rr2_data)
    );

endmodule

// File: rtl/irqc_chain_chk.sv
module irqc_chain_chk
    import irqc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            iei,
    input logic            ieo,
    input logic            inta,
    input logic            int_req_n,
    input logic            bus_oe,
    input irqc_cfg_t       cfg_q,
    input logic [NSRC-1:0] ius_q
);

    a_r1_cut_blocks_chain: assert property (@(posedge clk) disable iff (rst)
        cfg_q.dlc |-> !ieo);

    a_r2_reset_clears_cut: assert property (@(posedge clk)
        rst |=> (!cfg_q.dlc && ius_q == '0));

    a_r3_no_enable_in: assert property (@(posedge clk) disable iff (rst)
        !iei |-> !ieo);

    a_r3_service_holds_chain: assert property (@(posedge clk) disable iff (rst)
        (|ius_q) |-> !ieo);

    a_r4_nv_keeps_float: assert property (@(posedge clk) disable iff (rst)
        cfg_q.nv |-> !bus_oe);

    a_r6_no_request_without_iei: assert property (@(posedge clk) disable iff (rst)
        !iei |-> int_req_n);

    a_r7_drive_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (inta && !int_req_n));

    a_r8_ack_marks_service: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_req_n) |=> (|ius_q));

endmodule

bind irqc_chain irqc_chain_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iei       (iei),
    .ieo       (ieo),
    .inta      (inta),
    .int_req_n (int_req_n),
    .bus_oe    (bus_oe),
    .cfg_q     (cfg_q),
    .ius_q     (ius_q)
);

// File: tb/test_irqc_chain.sv
module test_irqc_chain;

    localparam int ND = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       top_iei;
    logic       inta;
    logic [ND:0] chain;
    logic [7:0] pend    [ND];
    logic       mie     [ND];
    logic       cfg_we  [ND];
    logic [2:0] cfg_wd  [ND];
    logic       base_we [ND];
    logic [7:0] base_wd [ND];
    logic       clr     [ND];
    logic       chb     [ND];
    logic       irqn    [ND];
    logic [7:0] dout    [ND];
    logic       oe      [ND];
    logic [7:0] rr2     [ND];

    assign chain[0] = top_iei;

    irqc_chain i_irqc_chain (
        .clk(clk), .rst(rst), .iei(chain[0]), .ieo(chain[1]), .pend(pend[0]), .mie(mie[0]),
        .cfg_we(cfg_we[0]), .cfg_wdata(cfg_wd[0]), .base_we(base_we[0]), .base_wdata(base_wd[0]),
        .inta(inta), .clr_ius(clr[0]), .int_req_n(irqn[0]), .bus_dout(dout[0]), .bus_oe(oe[0]),
        .rr2_chb(chb[0]), .rr2_data(rr2[0]));

    irqc_chain i_irqc_chain_mid (
        .clk(clk), .rst(rst), .iei(chain[1]), .ieo(chain[2]), .pend(pend[1]), .mie(mie[1]),
        .cfg_we(cfg_we[1]), .cfg_wdata(cfg_wd[1]), .base_we(base_we[1]), .base_wdata(base_wd[1]),
        .inta(inta), .clr_ius(clr[1]), .int_req_n(irqn[1]), .bus_dout(dout[1]), .bus_oe(oe[1]),
        .rr2_chb(chb[1]), .rr2_data(rr2[1]));

    irqc_chain i_irqc_chain_low (
        .clk(clk), .rst(rst), .iei(chain[2]), .ieo(chain[3]), .pend(pend[2]), .mie(mie[2]),
        .cfg_we(cfg_we[2]), .cfg_wdata(cfg_wd[2]), .base_we(base_we[2]), .base_wdata(base_wd[2]),
        .inta(inta), .clr_ius(clr[2]), .int_req_n(irqn[2]), .bus_dout(dout[2]), .bus_oe(oe[2]),
        .rr2_chb(chb[2]), .rr2_data(rr2[2]));

    int nchk  = 0;
    int nfail = 0;

    task automatic chk(input string tag, input string what, input int dev,
                       input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s dev%0d %s: actual %0h expected %0h", tag, dev, what, act, exp);
        end
    endtask

    function automatic int top_bit(input logic [7:0] v);
        int r;
        r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] put_code(input logic [7:0] b, input int code);
        logic [7:0] v;
        v = b;
        v[3:1] = (code < 0) ? 3'd0 : code[2:0];
        return v;
    endfunction

    // Behavioural reference model
    logic [7:0] m_ius  [ND];
    logic [7:0] m_base [ND];
    logic       m_dlc  [ND];
    logic       m_nv   [ND];
    logic       m_vis  [ND];

    always @(negedge clk) begin : model
        logic       iei_m, ieo_e, sel, oe_e;
        logic [7:0] reqv, dout_e, rr2_e, nxt;
        int         hu, hr;
        if (rst) begin
            for (int d = 0; d < ND; d++) begin
                m_ius[d] = '0; m_base[d] = '0; m_dlc[d] = 0; m_nv[d] = 0; m_vis[d] = 0;
            end
        end else begin
            iei_m = top_iei;
            for (int d = 0; d < ND; d++) begin
                hu   = top_bit(m_ius[d]);
                reqv = pend[d];
                for (int j = 0; j < 8; j++) if (j <= hu) reqv[j] = 1'b0;
                hr    = top_bit(reqv);
                sel   = iei_m && mie[d] && (hr >= 0);
                ieo_e = iei_m && !m_dlc[d] && (m_ius[d] == 0) && !(mie[d] && pend[d] != 0);
                oe_e  = inta && sel && !m_nv[d];
                dout_e = !oe_e ? 8'h00 : (m_vis[d] ? put_code(m_base[d], hr) : m_base[d]);
                rr2_e  = chb[d] ? put_code(m_base[d], top_bit(pend[d])) : m_base[d];
                chk("R1/R3", "ieo", d, int'(chain[d+1]), int'(ieo_e));
                chk("R6", "int_req_n", d, int'(irqn[d]), int'(!sel));
                chk("R4/R7", "bus_oe", d, int'(oe[d]), int'(oe_e));
                chk("R5", "bus_dout", d, int'(dout[d]), int'(dout_e));
                chk("R9", "rr2_data", d, int'(rr2[d]), int'(rr2_e));
                // state update for the coming edge (R8, R10)
                nxt = m_ius[d];
                if (clr[d] && hu >= 0) nxt[hu] = 1'b0;
                if (inta && sel) nxt[hr] = 1'b1;
                m_ius[d] = nxt;
                if (cfg_we[d]) begin
                    m_dlc[d] = cfg_wd[d][2]; m_nv[d] = cfg_wd[d][1]; m_vis[d] = cfg_wd[d][0];
                end
                if (base_we[d]) m_base[d] = base_wd[d];
                iei_m = ieo_e;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        inta = 0;
        for (int d = 0; d < ND; d++) begin
            cfg_we[d] = 0; base_we[d] = 0; clr[d] = 0;
        end
    endtask

    bit done = 0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        top_iei = 1; inta = 0;
        for (int d = 0; d < ND; d++) begin
            pend[d] = 0; mie[d] = 0; cfg_we[d] = 0; cfg_wd[d] = 0; base_we[d] = 0;
            base_wd[d] = 0; clr[d] = 0; chb[d] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #5;
        // R2: reset state seen at the ports
        chk("R2", "ieo end of chain", 2, int'(chain[3]), 1);
        chk("R2", "rr2 after reset", 1, int'(rr2[1]), 0);
        chk("R2", "int_req_n idle", 0, int'(irqn[0]), 1);

        // R10: program vectors and status-insert on the middle device
        for (int d = 0; d < ND; d++) begin
            base_we[d] = 1; base_wd[d] = 8'(8'h40 * (d + 1)); mie[d] = 1;
        end
        step();
        cfg_we[1] = 1; cfg_wd[1] = 3'b001;
        step();
        pend[1] = 8'b0010_0100; pend[2] = 8'h01;
        step();
        #5;
        chk("R6", "mid requests", 1, int'(irqn[1]), 0);
        chk("R6", "low blocked", 2, int'(irqn[2]), 1);
        chk("R3", "chain held by pending", 1, int'(chain[2]), 0);

        inta = 1;
        #5;
        chk("R5", "status vector", 1, int'(dout[1]), 8'h8A);
        chk("R7", "low floats", 2, int'(oe[2]), 0);
        step();
        pend[1] = 8'h04;      // source 5 withdrawn, source 2 masked by service
        step();
        #5;
        chk("R8", "masked by service", 1, int'(irqn[1]), 1);
        clr[1] = 1;
        step();
        #5;
        chk("R8", "requests after clear", 1, int'(irqn[1]), 0);
        inta = 1;
        #5;
        chk("R5", "second vector", 1, int'(dout[1]), 8'h84);
        step();
        clr[1] = 1; pend[1] = 0;
        step();
        inta = 1;
        #5;
        chk("R5", "plain vector", 2, int'(dout[2]), 8'hC0);
        step();
        clr[2] = 1;
        step();

        cfg_we[0] = 1; cfg_wd[0] = 3'b100;
        step();
        #5;
        chk("R1", "cut off chain", 0, int'(chain[1]), 0);
        chk("R1", "low silenced", 2, int'(irqn[2]), 1);
        cfg_we[0] = 1; cfg_wd[0] = 3'b000;
        cfg_we[2] = 1; cfg_wd[2] = 3'b011;
        step();
        inta = 1;
        #5;
        chk("R4", "no vector driven", 2, int'(oe[2]), 0);
        chk("R4", "bus idle value", 2, int'(dout[2]), 0);
        step();
        clr[2] = 1; pend[2] = 0;
        step();

        pend[1] = 8'h80; chb[1] = 1;
        #5;
        chk("R9", "second-channel read", 1, int'(rr2[1]), 8'h8E);
        chb[1] = 0;
        #2;
        chk("R9", "first-channel read", 1, int'(rr2[1]), 8'h80);
        step();

        // Random phase, model compared every cycle
        for (int k = 0; k < 600; k++) begin
            for (int d = 0; d < ND; d++) begin
                if ($urandom % 4 == 0) pend[d] = 8'($urandom) & 8'($urandom);
                if ($urandom % 10 == 0) mie[d] = ($urandom % 5) != 0;
                if ($urandom % 6 == 0) clr[d] = 1;
                if ($urandom % 12 == 0) begin
                    cfg_we[d] = 1;
                    cfg_wd[d] = {($urandom % 4) == 0, ($urandom % 3) == 0, 1'($urandom)};
                end
                if ($urandom % 20 == 0) begin base_we[d] = 1; base_wd[d] = 8'($urandom); end
                chb[d] = 1'($urandom);
            end
            top_iei = ($urandom % 8) != 0;
            inta = ($urandom % 3) == 0;
            @(posedge clk);
            #1;
            inta = 0;
            for (int d = 0; d < ND; d++) begin
                cfg_we[d] = 0; base_we[d] = 0; clr[d] = 0;
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule